// File: doc/BRIEF.md
# Single-Cycle Integer Subset Processor

This block is a 32-bit processor that runs one instruction every clock cycle. It supports a small integer subset: arithmetic and logic with an immediate operand, loading an upper immediate, word loads and stores, two jump-and-link forms and six conditional branches. Within one cycle an instruction is fetched, decoded and executed. Memory is accessed only for loads and stores. The result is written back on the next clock edge.

The block holds the program counter, a register file and an ALU. It reads instructions from a combinational instruction memory and drives a data memory port that has an address, write data, a write strobe and combinational read data. Register x0 always reads as zero. Larger constants are built by loading an upper immediate and then adding the low 12 bits with an immediate add.

Top module: `rv_core`

## Requirements
- R1: While `rst` is high, `dmem_we` stays low. On the cycle after a reset edge, `imem_addr` is 0.
- R2: Opcode 0010011 adds (funct3 000), ANDs (funct3 111) or ORs (funct3 110) rs1 with the immediate in bits 31:20, sign-extended, and writes the result to rd.
- R3: Opcode 0110111 writes bits 31:12 of the instruction into bits 31:12 of rd and clears bits 11:0. A following immediate add of the low part yields a full 32-bit constant.
- R4: Opcode 0000011 with funct3 010 reads the data word at rs1 plus the sign-extended bits 31:20 and writes it to rd.
- R5: Opcode 0100011 with funct3 010 drives `dmem_we` high for that one cycle. The address is rs1 plus the sign-extended immediate {bits 31:25, bits 11:7}, and the data is rs2. No other instruction raises `dmem_we`.
- R6: Opcode 1101111 writes PC+4 to rd and moves the PC by the sign-extended offset {31, 19:12, 20, 30:21, 0}.
- R7: Opcode 1100111 with funct3 000 writes PC+4 to rd. It jumps to rs1 plus the sign-extended bits 31:20, with bit 0 of the target cleared.
- R8: Opcode 1100011 compares rs1 with rs2 and selects the test by funct3: 000 equal, 001 not equal, 100 signed less, 101 signed greater-or-equal, 110 unsigned less, 111 unsigned greater-or-equal. A taken branch adds the offset {31, 7, 30:25, 11:8, 0} to the PC. A branch that is not taken goes to PC+4.
- R9: Register x0 reads as zero. Writes to x0 have no effect.
- R10: Any other opcode, or an unsupported funct3, writes no register and no memory, and the PC advances by 4.
- R11: Every instruction that is not a jump or a branch advances the PC by 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state updates on the rising edge |
| rst | input | 1 | Synchronous active-high reset |
| imem_addr | output | 32 | Byte address of the current instruction (the PC register) |
| imem_data | input | 32 | Instruction word at `imem_addr`, combinational |
| dmem_addr | output | 32 | Byte address for a load or store |
| dmem_wdata | output | 32 | Store data |
| dmem_we | output | 1 | Store strobe; memory writes on the rising edge |
| dmem_rdata | input | 32 | Load data at `dmem_addr`, combinational |

## Verification
Each instruction shows its effects within its own cycle. `imem_addr` holds the PC of the instruction being executed. `dmem_we`, `dmem_addr` and `dmem_wdata` belong to that same instruction. The register write and the new PC take effect at the next rising edge. The bench samples the ports on every falling edge. Each sample pops one expected PC, and each active store strobe pops one expected address/data pair. The test program stores register values so that every computed result becomes visible at the data port. Skipped instructions would write to marker addresses, and the final memory check confirms those addresses are untouched.

// File: rtl/rv_core_pkg.sv
package rv_core_pkg;
  localparam int XLEN = 32;
  localparam int RIDX = 5;

  localparam logic [6:0] OP_IMM    = 7'b0010011;
  localparam logic [6:0] OP_LUI    = 7'b0110111;
  localparam logic [6:0] OP_LOAD   = 7'b0000011;
  localparam logic [6:0] OP_STORE  = 7'b0100011;
  localparam logic [6:0] OP_JAL    = 7'b1101111;
  localparam logic [6:0] OP_JALR   = 7'b1100111;
  localparam logic [6:0] OP_BRANCH = 7'b1100011;

  typedef enum logic [1:0] {ALU_ADD, ALU_AND, ALU_OR, ALU_PASS} alu_fn_e;
  typedef enum logic [1:0] {WB_ALU, WB_MEM, WB_LINK} wb_src_e;

  typedef struct packed {
    logic            rf_wr;
    logic            mem_wr;
    logic            is_jal;
    logic            is_jalr;
    logic            is_br;
    alu_fn_e         alu_fn;
    wb_src_e         wb_src;
    logic [XLEN-1:0] imm;
  } ctrl_t;
endpackage

// File: rtl/rv_decode.sv
module rv_decode
  import rv_core_pkg::*;
(
  input  logic [31:0] instr,
  output ctrl_t       ctrl
);
  logic [6:0] op;
  logic [2:0] f3;
  logic [XLEN-1:0] imm_i, imm_s, imm_b, imm_u, imm_j;

  assign op = instr[6:0];
  assign f3 = instr[14:12];

  assign imm_i = {{(XLEN-12){instr[31]}}, instr[31:20]};
  assign imm_s = {{(XLEN-12){instr[31]}}, instr[31:25], instr[11:7]};
  assign imm_b = {{(XLEN-13){instr[31]}}, instr[31], instr[7], instr[30:25], instr[11:8], 1'b0};
  assign imm_u = {instr[31:12], 12'b0};
  assign imm_j = {{(XLEN-21){instr[31]}}, instr[31], instr[19:12], instr[20], instr[30:21], 1'b0};

  always_comb begin
    ctrl = '0;
    ctrl.alu_fn = ALU_ADD;
    ctrl.wb_src = WB_ALU;
    ctrl.imm    = imm_i;
    unique case (op)
      OP_IMM: begin
        ctrl.rf_wr = (f3 == 3'b000) || (f3 == 3'b111) || (f3 == 3'b110);
        ctrl.alu_fn = (f3 == 3'b111) ? ALU_AND :
                      (f3 == 3'b110) ? ALU_OR  : ALU_ADD;
      end
      OP_LUI: begin
        ctrl.rf_wr  = 1'b1;
        ctrl.alu_fn = ALU_PASS;
        ctrl.imm    = imm_u;
      end
      OP_LOAD: begin
        ctrl.rf_wr  = (f3 == 3'b010);
        ctrl.wb_src = WB_MEM;
      end
      OP_STORE: begin
        ctrl.mem_wr = (f3 == 3'b010);
        ctrl.imm    = imm_s;
      end
      OP_JAL: begin
        ctrl.rf_wr  = 1'b1;
        ctrl.is_jal = 1'b1;
        ctrl.wb_src = WB_LINK;
        ctrl.imm    = imm_j;
      end
      OP_JALR: begin
        ctrl.rf_wr   = (f3 == 3'b000);
        ctrl.is_jalr = (f3 == 3'b000);
        ctrl.wb_src  = WB_LINK;
      end
      OP_BRANCH: begin
        ctrl.is_br = (f3 != 3'b010) && (f3 != 3'b011);
        ctrl.imm   = imm_b;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/rv_regfile.sv
module rv_regfile #(
  parameter int W    = 32,
  parameter int NREG = 32,
  localparam int AW  = $clog2(NREG)
) (
  input  logic          clk,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_idx,
  input  logic [W-1:0]  wr_val,
  input  logic [AW-1:0] rd_idx_a,
  input  logic [AW-1:0] rd_idx_b,
  output logic [W-1:0]  rd_val_a,
  output logic [W-1:0]  rd_val_b
);
  logic [W-1:0] regs [NREG];

  always_ff @(posedge clk) begin
    if (wr_en && wr_idx != '0) regs[wr_idx] <= wr_val;
  end

  assign rd_val_a = (rd_idx_a == '0) ? '0 : regs[rd_idx_a];
  assign rd_val_b = (rd_idx_b == '0) ? '0 : regs[rd_idx_b];
endmodule

// File: rtl/rv_alu.sv
module rv_alu
  import rv_core_pkg::*;
(
  input  alu_fn_e         fn,
  input  logic [XLEN-1:0] a,
  input  logic [XLEN-1:0] b,
  output logic [XLEN-1:0] y
);
  always_comb begin
    unique case (fn)
      ALU_AND:  y = a & b;
      ALU_OR:   y = a | b;
      ALU_PASS: y = b;
      default:  y = a + b;
    endcase
  end
endmodule

// File: rtl/rv_brcmp.sv
module rv_brcmp
  import rv_core_pkg::*;
(
  input  logic [2:0]      cond,
  input  logic [XLEN-1:0] a,
  input  logic [XLEN-1:0] b,
  output logic            taken
);
  logic eq, lt_s, lt_u;
  assign eq   = (a == b);
  assign lt_s = $signed(a) < $signed(b);
  assign lt_u = a < b;

  always_comb begin
    unique case (cond)
      3'b000:  taken = eq;
      3'b001:  taken = !eq;
      3'b100:  taken = lt_s;
      3'b101:  taken = !lt_s;
      3'b110:  taken = lt_u;
      3'b111:  taken = !lt_u;
      default: taken = 1'b0;
    endcase
  end
endmodule

// File: rtl/rv_core.sv
module rv_core
  import rv_core_pkg::*;
#(
  parameter int          NREG     = 32,
  parameter logic [31:0] RESET_PC = 32'h0
) (
  input  logic            clk,
  input  logic            rst,
  output logic [XLEN-1:0] imem_addr,
  input  logic [31:0]     imem_data,
  output logic [XLEN-1:0] dmem_addr,
  output logic [XLEN-1:0] dmem_wdata,
  output logic            dmem_we,
  input  logic [XLEN-1:0] dmem_rdata
);
  localparam int AW = $clog2(NREG);

  ctrl_t           ctrl;
  logic [XLEN-1:0] pc_q, pc_next, pc_inc, pc_rel;
  logic [XLEN-1:0] rs1_val, rs2_val, alu_y, wb_val;
  logic            br_taken, rf_wr_en;
  logic [AW-1:0]   rs1_idx, rs2_idx, rd_idx;

  assign rs1_idx = imem_data[15 +: AW];
  assign rs2_idx = imem_data[20 +: AW];
  assign rd_idx  = imem_data[7 +: AW];

  rv_decode u_dec (.instr(imem_data), .ctrl(ctrl));

  rv_regfile #(.W(XLEN), .NREG(NREG)) u_rf (
    .clk(clk), .wr_en(rf_wr_en), .wr_idx(rd_idx), .wr_val(wb_val),
    .rd_idx_a(rs1_idx), .rd_idx_b(rs2_idx),
    .rd_val_a(rs1_val), .rd_val_b(rs2_val)
  );

  rv_alu u_alu (.fn(ctrl.alu_fn), .a(rs1_val), .b(ctrl.imm), .y(alu_y));

  rv_brcmp u_br (.cond(imem_data[14:12]), .a(rs1_val), .b(rs2_val), .taken(br_taken));

  assign pc_inc = pc_q + XLEN'(4);
  assign pc_rel = pc_q + ctrl.imm;

  always_comb begin
    if (ctrl.is_jal || (ctrl.is_br && br_taken)) pc_next = pc_rel;
    else if (ctrl.is_jalr)                        pc_next = {alu_y[XLEN-1:1], 1'b0};
    else                                          pc_next = pc_inc;
  end

  always_comb begin
    unique case (ctrl.wb_src)
      WB_MEM:  wb_val = dmem_rdata;
      WB_LINK: wb_val = pc_inc;
      default: wb_val = alu_y;
    endcase
  end

  assign rf_wr_en = ctrl.rf_wr && !rst;

  always_ff @(posedge clk) begin
    if (rst) pc_q <= RESET_PC;
    else     pc_q <= pc_next;
  end

  assign imem_addr  = pc_q;
  assign dmem_addr  = alu_y;
  assign dmem_wdata = rs2_val;
  assign dmem_we    = ctrl.mem_wr && !rst;
endmodule

// File: rtl/rv_core_chk.sv
module rv_core_chk
  import rv_core_pkg::*;
(
  input logic            clk,
  input logic            rst,
  input logic [XLEN-1:0] imem_addr,
  input logic [31:0]     imem_data,
  input logic            dmem_we,
  input logic            rf_wr,
  input logic [4:0]      rs1_idx,
  input logic [XLEN-1:0] rs1_val
);
  logic [6:0]      op;
  logic            flow, known;
  logic [XLEN-1:0] joff;

  assign op    = imem_data[6:0];
  assign flow  = (op == OP_JAL) || (op == OP_JALR) || (op == OP_BRANCH);
  assign known = (op == OP_IMM) || (op == OP_LUI) || (op == OP_LOAD) ||
                 (op == OP_STORE) || flow;
  assign joff  = {{(XLEN-21){imem_data[31]}}, imem_data[31], imem_data[19:12],
                  imem_data[20], imem_data[30:21], 1'b0};

  p_reset_pc_r1: assert property (@(posedge clk) rst |=> (imem_addr == RESET_PC_CHK));
  p_no_store_in_reset_r1: assert property (@(posedge clk) rst |-> !dmem_we);
  p_store_only_r5: assert property (@(posedge clk) disable iff (rst)
    dmem_we |-> (op == OP_STORE));
  p_jal_target_r6: assert property (@(posedge clk) disable iff (rst)
    (op == OP_JAL) |=> (imem_addr == $past(imem_addr) + $past(joff)));
  p_x0_zero_r9: assert property (@(posedge clk) disable iff (rst)
    (rs1_idx == 5'd0) |-> (rs1_val == '0));
  p_unknown_quiet_r10: assert property (@(posedge clk) disable iff (rst)
    !known |-> (!rf_wr && !dmem_we));
  p_seq_pc_r11: assert property (@(posedge clk) disable iff (rst)
    !flow |=> (imem_addr == $past(imem_addr) + XLEN'(4)));

  localparam logic [XLEN-1:0] RESET_PC_CHK = '0;
endmodule

bind rv_core rv_core_chk u_chk (
  .clk(clk), .rst(rst), .imem_addr(imem_addr), .imem_data(imem_data),
  .dmem_we(dmem_we), .rf_wr(rf_wr_en), .rs1_idx(rs1_idx), .rs1_val(rs1_val)
);

// File: tb/tb_rv_core.sv
module tb_rv_core;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] imem_addr, imem_data, dmem_addr, dmem_wdata, dmem_rdata;
  logic        dmem_we;

  logic [31:0] imem [64];
  logic [31:0] dmem [64];

  int checks = 0;
  int fails  = 0;

  logic [31:0] exp_pc[$];
  string       exp_pc_tag[$];
  logic [31:0] exp_sa[$];
  logic [31:0] exp_sd[$];
  string       exp_s_tag[$];

  always #4 clk = ~clk;

  rv_core dut (
    .clk(clk), .rst(rst), .imem_addr(imem_addr), .imem_data(imem_data),
    .dmem_addr(dmem_addr), .dmem_wdata(dmem_wdata), .dmem_we(dmem_we),
    .dmem_rdata(dmem_rdata)
  );

  assign imem_data  = imem[imem_addr[7:2]];
  assign dmem_rdata = dmem[dmem_addr[7:2]];
  always @(posedge clk) if (dmem_we) dmem[dmem_addr[7:2]] <= dmem_wdata;

  function automatic logic [31:0] e_i(logic [11:0] im, logic [4:0] rs1, logic [2:0] f3,
                                      logic [4:0] rd, logic [6:0] op);
    return {im, rs1, f3, rd, op};
  endfunction
  function automatic logic [31:0] e_s(logic [11:0] im, logic [4:0] rs2, logic [4:0] rs1);
    return {im[11:5], rs2, rs1, 3'b010, im[4:0], 7'b0100011};
  endfunction
  function automatic logic [31:0] e_b(logic [12:0] o, logic [4:0] rs2, logic [4:0] rs1,
                                      logic [2:0] f3);
    return {o[12], o[10:5], rs2, rs1, f3, o[4:1], o[11], 7'b1100011};
  endfunction
  function automatic logic [31:0] e_j(logic [20:0] o, logic [4:0] rd);
    return {o[20], o[10:1], o[11], o[19:12], rd, 7'b1101111};
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic push_pc(logic [31:0] pc, string tag);
    exp_pc.push_back(pc);
    exp_pc_tag.push_back(tag);
  endtask

  task automatic push_st(logic [31:0] a, logic [31:0] d, string tag);
    exp_sa.push_back(a);
    exp_sd.push_back(d);
    exp_s_tag.push_back(tag);
  endtask

  // Monitor: one PC per cycle, one store item per strobe
  always @(negedge clk) begin
    if (!rst) begin
      if (exp_pc.size() != 0) chk({"pc ", exp_pc_tag.pop_front()}, imem_addr, exp_pc.pop_front());
      if (dmem_we) begin
        if (exp_sa.size() == 0) chk("R5 unexpected store addr", dmem_addr, 32'hxxxxxxxx);
        else begin
          chk({"store addr ", exp_s_tag[0]}, dmem_addr, exp_sa.pop_front());
          chk({"store data ", exp_s_tag.pop_front()}, dmem_wdata, exp_sd.pop_front());
        end
      end
    end
  end

  localparam logic [6:0] OI = 7'b0010011;

  initial begin
    for (int i = 0; i < 64; i++) begin imem[i] = 32'h0; dmem[i] = 32'h0; end
    imem[0]  = {20'hbeef1, 5'd5, 7'b0110111};           // LUI x5
    imem[1]  = e_i(12'h234, 5, 3'b000, 5, OI);          // x5 += 0x234
    imem[2]  = e_s(12'd0, 5, 0);
    imem[3]  = e_i(12'hfff, 0, 3'b000, 6, OI);          // x6 = -1
    imem[4]  = e_i(12'h0f0, 6, 3'b111, 7, OI);          // x7 = x6 & 0xf0
    imem[5]  = e_i(12'h800, 7, 3'b110, 8, OI);          // x8 = x7 | sext(0x800)
    imem[6]  = e_s(12'd4, 8, 0);
    imem[7]  = e_s(12'd8, 7, 0);
    imem[8]  = e_i(12'd5, 0, 3'b000, 0, OI);            // write to x0
    imem[9]  = e_s(12'd12, 0, 0);
    imem[10] = e_i(12'd0, 0, 3'b010, 9, 7'b0000011);    // LW x9, 0(x0)
    imem[11] = e_i(12'd32, 0, 3'b000, 10, OI);
    imem[12] = e_s(12'hff4, 9, 10);                     // SW x9, -12(x10)
    imem[13] = e_j(21'd12, 1);                          // JAL x1, +12
    imem[14] = e_i(12'd1, 0, 3'b000, 11, OI);
    imem[15] = e_s(12'd40, 6, 0);
    imem[16] = e_s(12'd24, 1, 0);
    imem[17] = e_b(13'd8, 7, 7, 3'b000);                // BEQ taken
    imem[18] = e_s(12'd44, 6, 0);
    imem[19] = e_b(13'd8, 7, 7, 3'b001);                // BNE not taken
    imem[20] = e_b(13'd8, 7, 6, 3'b100);                // BLT -1<0xf0 taken
    imem[21] = e_s(12'd48, 6, 0);
    imem[22] = e_b(13'd8, 7, 6, 3'b110);                // BLTU not taken
    imem[23] = e_b(13'd8, 6, 7, 3'b101);                // BGE taken
    imem[24] = e_s(12'd52, 6, 0);
    imem[25] = e_b(13'd8, 7, 6, 3'b111);                // BGEU taken
    imem[26] = e_s(12'd56, 6, 0);
    imem[27] = e_i(12'd125, 0, 3'b000, 12, OI);
    imem[28] = e_i(12'd0, 12, 3'b000, 13, 7'b1100111);  // JALR x13, 0(x12)
    imem[29] = e_s(12'd60, 6, 0);
    imem[30] = e_s(12'd60, 6, 0);
    imem[31] = e_s(12'd32, 13, 0);
    imem[32] = 32'h0000_03ff;                           // unknown opcode, rd=x7
    imem[33] = e_s(12'd36, 7, 0);
    imem[34] = e_j(21'd0, 0);                           // spin

    // Reset state (R1)
    repeat (3) @(posedge clk);
    #1;
    chk("R1 reset pc", imem_addr, 32'h0);
    chk("R1 no store in reset", {31'b0, dmem_we}, 32'h0);

    for (int a = 0; a <= 52; a += 4) push_pc(a, (a == 0) ? "R1" : "R11");
    push_pc(64, "R6 jal");
    push_pc(68, "R11");
    push_pc(76, "R8 beq taken");
    push_pc(80, "R8 bne not taken");
    push_pc(88, "R8 blt taken");
    push_pc(92, "R8 bltu not taken");
    push_pc(100, "R8 bge taken");
    push_pc(108, "R8 bgeu taken");
    push_pc(112, "R11");
    push_pc(124, "R7 jalr bit0 cleared");
    push_pc(128, "R11");
    push_pc(132, "R10 unknown advances");
    push_pc(136, "R11");
    push_pc(136, "R6 jal zero");
    push_pc(136, "R6 jal zero");

    push_st(0,  32'hbeef1234, "R3 lui+addi");
    push_st(4,  32'hfffff8f0, "R2 ori sext");
    push_st(8,  32'h000000f0, "R2 andi");
    push_st(12, 32'h00000000, "R9 x0");
    push_st(20, 32'hbeef1234, "R4 load / R5 split imm");
    push_st(24, 32'd56,       "R6 link");
    push_st(32, 32'd116,      "R7 link");
    push_st(36, 32'h000000f0, "R10 no reg write");

    rst = 1'b0;

    begin
      int cyc = 0;
      while (exp_pc.size() != 0 && cyc < 1000) begin
        @(negedge clk);
        cyc++;
      end
      if (cyc >= 1000) chk("watchdog", 32'd0, 32'd1);
    end
    @(negedge clk);
    #1;
    chk("R5 all stores seen", exp_sa.size(), 32'd0);
    chk("R8 skipped store", dmem[11], 32'h0);
    chk("R8 skipped store", dmem[12], 32'h0);
    chk("R6 skipped store", dmem[10], 32'h0);
    chk("R7 skipped store", dmem[15], 32'h0);
    chk("R4 memory word", dmem[5], 32'hbeef1234);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule